// File: doc/BRIEF.md
# Lower-MAC Transmit Frame Builder

The block sits between the lower MAC and the PHY on the transmit side. A request carries a small transmit parameter vector (frame format, payload length, modulation and coding index, power level, scrambler seed), a per-packet destination address and a frame kind (data or acknowledgement). The block checks the vector. A valid request is turned into a MAC frame and streamed out one byte per cycle: a fixed header, the payload bytes pulled from a valid/ready input stream, then a 32-bit CRC frame check sequence. An invalid request is dropped without a byte being sent and without any payload being consumed.

Both outcomes close with a one-cycle end indication. A flag beside it tells a rejected request apart from a completed one. An internal 12-bit sequence counter stamps each data frame and advances once for every data frame that is sent. The accepted power level, seed, format and coding index are held on configuration outputs for the PHY while the frame is in flight.

The controller has six named states. `ST_IDLE` waits for a request. On `req_valid` it moves to `ST_HDR` if the vector is valid and to `ST_DROP` if it is not. `ST_HDR` sends the header bytes. After the last header byte it goes to `ST_BODY` for a data frame or straight to `ST_FCS` for an acknowledgement. `ST_BODY` forwards payload bytes and moves to `ST_FCS` after the last one. `ST_FCS` sends four check bytes and then goes to `ST_DONE`. `ST_DONE` raises the end indication, advances the sequence counter for data frames and returns to `ST_IDLE`. `ST_DROP` raises the end indication with the reject flag set and returns to `ST_IDLE`.

Top module: `mac_tx_framer`

## Requirements
- R1: A vector is valid only when all of the following hold: the format code is 0 (legacy OFDM, coding index 0..7) or 1 (very high throughput, coding index 0..9); the coding index is within the range for that format; the length is 1..4095. Format codes 2 and 3 are always invalid.
- R2: An invalid request emits no output byte and consumes no payload byte. In the cycle after acceptance, `txend` and `txend_rej` are both high for exactly one cycle.
- R3: A valid request ends with `txend` high and `txend_rej` low for one cycle, in the cycle after the last check byte. The block is ready for the next request in the following cycle.
- R4: A data frame header is 24 bytes, in this order: frame control 0x08 0x00; duration 0x00 0x00; destination address, `req_dest[7:0]` first; local source address `SRC_ADDR`, bits 7:0 first; six zero bytes; sequence control `{seq[3:0],4'b0}` then `seq[11:4]`.
- R5: An acknowledgement frame is frame control 0xD4 0x00, duration 0x00 0x00, the six destination bytes, then the check sequence. It consumes no payload.
- R6: A data frame carries exactly `req_len` payload bytes, in input order. `pl_ready` is high only during the payload phase. `out_valid` follows `pl_valid` in that phase, so a gap at the input becomes a gap at the output.
- R7: The frame ends with the CRC-32 over every byte before it: polynomial 0x04C11DB7, reflected, initial value all ones, final inversion. The least significant byte is sent first.
- R8: The sequence number is 0 after reset and increases by one for each data frame sent, wrapping from 4095 to 0. Acknowledgement frames and rejected requests leave it unchanged.
- R9: `req_ready` is high only in the idle state. A request presented while a frame is in progress is ignored.
- R10: After reset, `req_ready` is high and `out_valid`, `pl_ready`, `txend` and `txend_rej` are low.
- R11: The `phy_*` outputs take the format, coding index, power and seed of each accepted valid request and hold them until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transmit request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_fmt | input | 2 | Frame format code |
| req_len | input | LEN_W | Payload length in bytes |
| req_mcs | input | MCS_W | Modulation and coding index |
| req_pwr | input | PWR_W | Transmit power level |
| req_seed | input | SEED_W | Scrambler seed |
| req_is_ack | input | 1 | 1 = acknowledgement frame, 0 = data frame |
| req_dest | input | 48 | Destination address |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Frame byte present |
| out_data | output | 8 | Frame byte |
| txend | output | 1 | End-of-transmission indication |
| txend_rej | output | 1 | End indication is a rejection |
| phy_fmt | output | 2 | Held format of the frame |
| phy_mcs | output | MCS_W | Held coding index |
| phy_pwr | output | PWR_W | Held power level |
| phy_seed | output | SEED_W | Held scrambler seed |

## Verification
The assertions check the cycle-level rules on every cycle: payload bytes pass straight through in the payload phase, acceptance drops `req_ready` on the next cycle, a rejection follows an acceptance immediately, the end indication never overlaps a frame byte and is followed by the idle state, and the PHY configuration stays fixed while a frame runs. Only the bench scenarios can show the content. Its sweep over every format and coding-index pair, the length limits, stalled payload streams, acknowledgement frames, requests arriving while busy and a full wrap of the sequence counter are compared byte by byte against frames and CRCs computed in the bench.

// File: rtl/mac_tx_pkg.sv
package mac_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_FCS,
        ST_DONE,
        ST_DROP
    } tx_state_e;

    localparam int SEQ_W        = 12;
    localparam int HDR_IDX_W    = 5;
    localparam int DATA_HDR_LEN = 24;
    localparam int ACK_HDR_LEN  = 10;
    localparam int FCS_LEN      = 4;

    localparam logic [1:0] FMT_OFDM = 2'd0;
    localparam logic [1:0] FMT_VHT  = 2'd1;

    // frame control first byte: version 00, type in [3:2], subtype in [7:4]
    localparam logic [7:0] FC0_DATA = 8'h08;
    localparam logic [7:0] FC0_ACK  = 8'hD4;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mac_txvec_check.sv
module mac_txvec_check #(
    parameter int LEN_W      = 12,
    parameter int MCS_W      = 4,
    parameter int MAX_MCS_A  = 7,
    parameter int MAX_MCS_AC = 9
) (
    input  logic [1:0]       fmt,
    input  logic [MCS_W-1:0] mcs,
    input  logic [LEN_W-1:0] len,
    output logic             ok
);
    import mac_tx_pkg::*;

    logic fmt_ok;

    always_comb begin
        fmt_ok = 1'b0;
        if (fmt == FMT_OFDM) fmt_ok = (int'(mcs) <= MAX_MCS_A);
        else if (fmt == FMT_VHT) fmt_ok = (int'(mcs) <= MAX_MCS_AC);
        ok = fmt_ok && (len != '0);
    end
endmodule

// File: rtl/mac_hdr_byte.sv
module mac_hdr_byte #(
    parameter logic [47:0] SRC_ADDR = 48'h0A1B2C3D4E5F
) (
    input  logic [mac_tx_pkg::HDR_IDX_W-1:0] idx,
    input  logic                             is_ack,
    input  logic [47:0]                      dest,
    input  logic [mac_tx_pkg::SEQ_W-1:0]     seq,
    output logic [7:0]                       hbyte
);
    import mac_tx_pkg::*;

    always_comb begin
        hbyte = 8'h00;
        if (idx == 5'd0) hbyte = is_ack ? FC0_ACK : FC0_DATA;
        for (int i = 0; i < 6; i++) begin
            if (idx == HDR_IDX_W'(4 + i))  hbyte = dest[8*i +: 8];
            if (idx == HDR_IDX_W'(10 + i)) hbyte = SRC_ADDR[8*i +: 8];
        end
        if (idx == 5'd22) hbyte = {seq[3:0], 4'h0};
        if (idx == 5'd23) hbyte = seq[11:4];
    end
endmodule

// File: rtl/mac_crc32.sv
module mac_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    import mac_tx_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= 32'hFFFF_FFFF;
        else if (en)       crc_q <= crc32_step(crc_q, din);
    end
endmodule

// File: rtl/mac_tx_framer.sv
module mac_tx_framer #(
    parameter int          LEN_W    = 12,
    parameter int          MCS_W    = 4,
    parameter int          PWR_W    = 6,
    parameter int          SEED_W   = 7,
    parameter logic [47:0] SRC_ADDR = 48'h0A1B2C3D4E5F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_fmt,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MCS_W-1:0]  req_mcs,
    input  logic [PWR_W-1:0]  req_pwr,
    input  logic [SEED_W-1:0] req_seed,
    input  logic              req_is_ack,
    input  logic [47:0]       req_dest,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [7:0]        pl_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              txend,
    output logic              txend_rej,
    output logic [1:0]        phy_fmt,
    output logic [MCS_W-1:0]  phy_mcs,
    output logic [PWR_W-1:0]  phy_pwr,
    output logic [SEED_W-1:0] phy_seed
);
    import mac_tx_pkg::*;

    localparam logic [LEN_W-1:0] LAST_DATA_HDR = LEN_W'(DATA_HDR_LEN - 1);
    localparam logic [LEN_W-1:0] LAST_ACK_HDR  = LEN_W'(ACK_HDR_LEN - 1);
    localparam logic [LEN_W-1:0] LAST_FCS      = LEN_W'(FCS_LEN - 1);

    tx_state_e          state_q, state_d;
    logic [LEN_W-1:0]   idx_q;
    logic [LEN_W-1:0]   len_q;
    logic               ack_q;
    logic [47:0]        dest_q;
    logic [SEQ_W-1:0]   seq_q;
    logic               vec_ok;
    logic               accept;
    logic [7:0]         hdr_b;
    logic [31:0]        crc_q;
    logic [31:0]        fcs;
    logic               hdr_last;

    mac_txvec_check #(.LEN_W(LEN_W), .MCS_W(MCS_W)) u_vchk (
        .fmt(req_fmt), .mcs(req_mcs), .len(req_len), .ok(vec_ok)
    );

    mac_hdr_byte #(.SRC_ADDR(SRC_ADDR)) u_hdr (
        .idx(idx_q[HDR_IDX_W-1:0]), .is_ack(ack_q), .dest(dest_q),
        .seq(seq_q), .hbyte(hdr_b)
    );

    mac_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .en(out_valid && (state_q != ST_FCS)), .din(out_data), .crc_q(crc_q)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign hdr_last = ack_q ? (idx_q == LAST_ACK_HDR) : (idx_q == LAST_DATA_HDR);
    assign fcs      = ~crc_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = vec_ok ? ST_HDR : ST_DROP;
            ST_HDR:  if (hdr_last)  state_d = ack_q ? ST_FCS : ST_BODY;
            ST_BODY: if (pl_valid && (idx_q == len_q - 1'b1)) state_d = ST_FCS;
            ST_FCS:  if (idx_q == LAST_FCS) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            ST_DROP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) idx_q <= '0;
            else if (out_valid)     idx_q <= idx_q + 1'b1;
        end
    end

    // request capture, sequence counter, PHY configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            ack_q    <= 1'b0;
            dest_q   <= '0;
            seq_q    <= '0;
            phy_fmt  <= '0;
            phy_mcs  <= '0;
            phy_pwr  <= '0;
            phy_seed <= '0;
        end else begin
            if (accept) begin
                len_q  <= req_len;
                ack_q  <= req_is_ack;
                dest_q <= req_dest;
                if (vec_ok) begin
                    phy_fmt  <= req_fmt;
                    phy_mcs  <= req_mcs;
                    phy_pwr  <= req_pwr;
                    phy_seed <= req_seed;
                end
            end
            if (state_q == ST_DONE && !ack_q) seq_q <= seq_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        pl_ready  = (state_q == ST_BODY);
        txend     = (state_q == ST_DONE) || (state_q == ST_DROP);
        txend_rej = (state_q == ST_DROP);
        out_valid = 1'b0;
        out_data  = 8'h00;
        unique case (state_q)
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_b;
            end
            ST_BODY: begin
                out_valid = pl_valid;
                out_data  = pl_data;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs[8*idx_q[1:0] +: 8];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mac_tx_framer_chk.sv
module mac_tx_framer_chk #(
    parameter int MCS_W  = 4,
    parameter int PWR_W  = 6,
    parameter int SEED_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              pl_valid,
    input logic              pl_ready,
    input logic [7:0]        pl_data,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic              txend,
    input logic              txend_rej,
    input logic [1:0]        phy_fmt,
    input logic [MCS_W-1:0]  phy_mcs,
    input logic [PWR_W-1:0]  phy_pwr,
    input logic [SEED_W-1:0] phy_seed
);
    // R6
    payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_ready && pl_valid) |-> (out_valid && out_data == pl_data));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    reject_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txend && txend_rej) |-> $past(req_valid && req_ready));

    // R3
    idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txend |=> req_ready);

    // R3
    end_not_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, txend}));

    // R11
    phy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |->
            ($stable(phy_fmt) && $stable(phy_mcs) && $stable(phy_pwr) && $stable(phy_seed)));
endmodule

bind mac_tx_framer mac_tx_framer_chk #(.MCS_W(MCS_W), .PWR_W(PWR_W), .SEED_W(SEED_W)) u_chk (.*);

// File: tb/sim_mac_tx_framer.sv
module sim_mac_tx_framer;
    localparam logic [47:0] SRC = 48'h0A1B2C3D4E5F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_fmt = '0;
    logic [11:0] req_len = '0;
    logic [3:0]  req_mcs = '0;
    logic [5:0]  req_pwr = '0;
    logic [6:0]  req_seed = '0;
    logic        req_is_ack = 1'b0;
    logic [47:0] req_dest = '0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [7:0]  pl_data;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        txend, txend_rej;
    logic [1:0]  phy_fmt;
    logic [3:0]  phy_mcs;
    logic [5:0]  phy_pwr;
    logic [6:0]  phy_seed;

    int checks = 0;
    int errors = 0;
    int pay_cnt = 0;
    int end_cnt = 0;
    int gap_mode = 0;
    int gcnt = 0;
    logic [11:0] exp_seq = '0;
    logic [7:0] cap_q[$];
    logic [7:0] exp_q[$];
    logic last_rej;

    mac_tx_framer #(.SRC_ADDR(SRC)) u0 (.*);

    always #5 clk = ~clk;

    assign pl_data = 8'((pay_cnt * 13 + 5) & 255);

    always @(posedge clk) begin
        if (pl_valid && pl_ready) pay_cnt <= pay_cnt + 1;
        if (out_valid) cap_q.push_back(out_data);
        if (txend) begin
            end_cnt <= end_cnt + 1;
            last_rej <= txend_rej;
        end
    end

    always @(negedge clk) begin
        gcnt <= gcnt + 1;
        pl_valid <= (gap_mode != 0) ? ((gcnt % 3) != 1) : 1'b1;
    end

    initial begin
        #1900000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] r;
        foreach (q[i]) begin
            logic [7:0] rb;
            for (int k = 0; k < 8; k++) rb[k] = q[i][7-k];
            c = c ^ {rb, 24'h0};
            for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        for (int k = 0; k < 32; k++) r[k] = c[31-k];
        return ~r;
    endfunction

    task automatic build_exp(input bit ack, input logic [47:0] dest, input int len, input int base);
        logic [31:0] f;
        exp_q.delete();
        exp_q.push_back(ack ? 8'hD4 : 8'h08);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        for (int i = 0; i < 6; i++) exp_q.push_back(dest[8*i +: 8]);
        if (!ack) begin
            for (int i = 0; i < 6; i++) exp_q.push_back(SRC[8*i +: 8]);
            for (int i = 0; i < 6; i++) exp_q.push_back(8'h00);
            exp_q.push_back({exp_seq[3:0], 4'h0});
            exp_q.push_back(exp_seq[11:4]);
            for (int i = 0; i < len; i++) exp_q.push_back(8'(((base + i) * 13 + 5) & 255));
        end
        f = ref_crc(exp_q);
        for (int i = 0; i < 4; i++) exp_q.push_back(f[8*i +: 8]);
    endtask

    // sends one request; poke != 0 presents a stray request while busy
    task automatic run_frame(input logic [1:0] fmt, input logic [3:0] mcs, input int len,
                             input bit ack, input logic [47:0] dest, input int poke);
        int base = pay_cnt;
        int e0 = end_cnt;
        bit valid = ((fmt == 2'd0 && mcs <= 7) || (fmt == 2'd1 && mcs <= 9)) && len >= 1 && len <= 4095;
        int hdr_n = ack ? 10 : 24;
        int mism;
        cap_q.delete();
        @(negedge clk);
        req_fmt = fmt; req_mcs = mcs; req_len = 12'(len); req_is_ack = ack; req_dest = dest;
        req_pwr = 6'(mcs + 3); req_seed = 7'(len + 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke != 0) begin
            repeat (4) @(negedge clk);
            req_fmt = 2'd0; req_mcs = 4'd1; req_len = 12'd2; req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (end_cnt == e0) @(negedge clk);
        if (!valid) begin
            chk(last_rej == 1'b1, "R1 R2 reject flag", last_rej, 1);
            chk(cap_q.size() == 0, "R2 no bytes on reject", cap_q.size(), 0);
            chk(pay_cnt == base, "R2 no payload on reject", pay_cnt - base, 0);
        end else begin
            build_exp(ack, dest, len, base);
            chk(last_rej == 1'b0, "R1 R3 accepted end flag", last_rej, 0);
            chk(cap_q.size() == exp_q.size(), "R3 frame length", cap_q.size(), exp_q.size());
            mism = -1;
            for (int i = 0; i < hdr_n && i < cap_q.size(); i++)
                if (mism < 0 && cap_q[i] !== exp_q[i]) mism = i;
            chk(mism < 0, ack ? "R5 ack header" : "R4 R8 data header",
                mism < 0 ? 0 : cap_q[mism], mism < 0 ? 0 : exp_q[mism]);
            mism = -1;
            for (int i = hdr_n; i < exp_q.size() - 4 && i < cap_q.size(); i++)
                if (mism < 0 && cap_q[i] !== exp_q[i]) mism = i;
            chk(mism < 0, "R6 payload", mism < 0 ? 0 : cap_q[mism], mism < 0 ? 0 : exp_q[mism]);
            chk(pay_cnt - base == (ack ? 0 : len), "R5 R6 payload count", pay_cnt - base, ack ? 0 : len);
            if (cap_q.size() == exp_q.size())
                chk(cap_q[$-3:$] == exp_q[$-3:$], "R7 check sequence",
                    {cap_q[$], cap_q[$-1], cap_q[$-2], cap_q[$-3]},
                    {exp_q[$], exp_q[$-1], exp_q[$-2], exp_q[$-3]});
            chk(phy_mcs == mcs && phy_fmt == fmt && phy_pwr == 6'(mcs + 3) && phy_seed == 7'(len + 1),
                "R11 phy config", {phy_fmt, phy_mcs}, {fmt, mcs});
            if (!ack) exp_seq = exp_seq + 1'b1;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R3 R9 ready after end", req_ready, 1);
        chk(end_cnt == e0 + 1, "R9 single end indication", end_cnt - e0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
        chk(out_valid == 1'b0 && pl_ready == 1'b0, "R10 stream idle", {out_valid, pl_ready}, 0);
        chk(txend == 1'b0 && txend_rej == 1'b0, "R10 no end", {txend, txend_rej}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && out_valid == 1'b0, "R10 after release", {req_ready, out_valid}, 2);

        // R1 sweep: every format and coding index
        for (int f = 0; f < 4; f++)
            for (int m = 0; m < 16; m++)
                run_frame(2'(f), 4'(m), 3, 1'b0, 48'h112233445566 + 48'(m), 0);

        // R1 length limits
        run_frame(2'd0, 4'd2, 0, 1'b0, 48'hA0A1A2A3A4A5, 0);
        run_frame(2'd1, 4'd0, 1, 1'b0, 48'hA0A1A2A3A4A5, 0);
        run_frame(2'd1, 4'd9, 4095, 1'b0, 48'hB1B2B3B4B5B6, 0);

        // R5 acknowledgement frames, R8 no sequence advance
        run_frame(2'd0, 4'd0, 5, 1'b1, 48'hC0FFEE123456, 0);
        run_frame(2'd3, 4'd0, 5, 1'b1, 48'hC0FFEE123456, 0);

        // R6 stalled payload input
        gap_mode = 1;
        run_frame(2'd0, 4'd7, 40, 1'b0, 48'h010203040506, 0);
        run_frame(2'd1, 4'd4, 7, 1'b1, 48'h010203040506, 0);
        gap_mode = 0;

        // R9 stray request while busy
        run_frame(2'd0, 4'd3, 20, 1'b0, 48'hDEADBEEF0001, 1);

        // R8 sequence wrap 4095 -> 0
        while (exp_seq != 12'd0)
            run_frame(2'd0, 4'd0, 1, 1'b0, 48'h665544332211, 0);
        run_frame(2'd0, 4'd0, 1, 1'b0, 48'h665544332211, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule